// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache Controller

This block keeps the bookkeeping state of a small two-way set-associative instruction cache: one tag, valid bit and lock bit per way, and one replacement bit per set. Core fetches are looked up against this state in the same cycle. On a miss the block picks a victim way and asks an external line-fill agent for the line. The agent answers with a done or an error pulse. The data array and the real bus protocol sit outside the block.

Software drives the cache through two registers. The address register holds a line address. Writing a command code into the control/status register starts a maintenance operation. The operations are: invalidate one line, invalidate the whole cache, and load-and-lock one line. A locked line behaves like fixed instruction memory. It is never replaced and no invalidate removes it. The control/status register reads back a busy flag and a two-bit error type, and a read clears the error type. The two cache-wide operations are privileged. If they are attempted while the core is in problem state, the block raises a program-interrupt request and changes no state.

Addresses at the ports are line addresses: the low INDEX_W bits select the set and the rest form the tag.

Top module: `lock_cache_ctl`

## Requirements
- R1: While a line fill is outstanding, csr_rdata[0] (busy) is 1, fetch_hit is 0 and fetch_stall follows fetch_req. A command written while busy is ignored.
- R2: A fetch that hits raises fetch_hit in the same cycle. On a miss, fill_req rises from the next cycle with fill_line equal to the fetched line and stays stable until fill_done or fill_err. After fill_done the line hits.
- R3: On a miss the victim is the way named by the set's replacement bit, unless that way is locked. Each hit or completed fill points the bit at the other way.
- R4: Command code 1 (block invalidate) invalidates the line held in the address register if it is present and unlocked. It works at any privilege, never raises prog_irq and never sets an error. A locked line stays valid.
- R5: Command codes 2 and 3 written while problem_state=1 raise prog_irq for exactly the one cycle after the write and change no cache state.
- R6: Command code 2 (invalidate all) clears every unlocked line in one cycle and keeps locked lines valid. Each set's replacement bit then names its unlocked way, or way 0 if both ways are unlocked.
- R7: Command code 3 (load-and-lock) locks the hitting way on a hit. On a miss it fills an unlocked way and locks it when the fill is done. A locked way is never chosen as a victim.
- R8: If load-and-lock misses and both ways of the set are locked, the error type becomes 1 (csr_rdata[2:1]=01). Nothing is filled or locked.
- R9: A fill_err reply leaves the line invalid and unlocked, sets the error type to 2 (csr_rdata[2:1]=10) and drops busy.
- R10: csr_rdata is {error type[1:0], busy}. A cycle with csr_rd=1 clears the error type from the next cycle, unless a new error is set in that cycle.
- R11: After reset every line is invalid and unlocked, and csr_rdata, fill_req, prog_irq and fetch_stall are 0.
- R12: A fetch miss into a set whose two ways are both locked still requests the line, but allocates nothing. The line misses again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Core fetch request |
| fetch_line | input | LINE_W | Line address of the fetch |
| fetch_hit | output | 1 | Fetch served from the cache this cycle |
| fetch_stall | output | 1 | Fetch requested but not served |
| problem_state | input | 1 | Core runs unprivileged |
| csr_wr | input | 1 | Write strobe of the control/status register |
| csr_wdata | input | 2 | Command code (1 block invalidate, 2 invalidate all, 3 load-and-lock) |
| csr_rd | input | 1 | Read strobe; clears the error type |
| csr_rdata | output | 3 | {error type, busy} |
| adr_wr | input | 1 | Write strobe of the address register |
| adr_wdata | input | LINE_W | Line address for commands |
| prog_irq | output | 1 | Program-interrupt request on a privilege violation |
| fill_req | output | 1 | Line fill requested |
| fill_line | output | LINE_W | Line address to fill |
| fill_done | input | 1 | Fill finished successfully |
| fill_err | input | 1 | Fill finished with a bus error |

## Verification
Lookups are run with sequences of lines that all map to one set, so each new miss must choose between a recently used way, a stale way and a locked way. A wrong replacement bit or a missing lock override then shows up as an earlier line that misses. The three commands are each issued in problem state and in privileged state, against present, absent, locked and unlocked lines. This separates the privilege check from the lock protection and from the invalidate action. A set with both ways locked, a fill answered with an error, and a command written during a fill cover the error codes, the bypass fill and the busy gating.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE      = 2'd0,
    CMD_INV_BLK   = 2'd1,
    CMD_INV_ALL   = 2'd2,
    CMD_LOAD_LOCK = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_NO_WAY = 2'd1,
    ERR_BUS    = 2'd2
  } err_e;

  typedef enum logic [2:0] {
    UPD_NONE,
    UPD_INV,
    UPD_KILL,
    UPD_FILL,
    UPD_LOCK,
    UPD_TOUCH
  } upd_e;

  typedef enum logic {
    ST_IDLE,
    ST_FILL
  } st_e;
endpackage

// File: rtl/cc_set_state.sv
module cc_set_state
  import cc_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel,
  input  upd_e                   op,
  input  logic                   way,
  input  logic [TAG_W-1:0]       tag_in,
  input  logic                   lock_in,
  input  logic                   inv_all,
  output logic [1:0]             valid_o,
  output logic [1:0]             lock_o,
  output logic                   lru_o,
  output logic [1:0][TAG_W-1:0]  tag_o
);
  logic [1:0]            v_q, v_n, l_q, l_n;
  logic                  lru_q, lru_n;
  logic [1:0][TAG_W-1:0] t_q, t_n;
  logic                  en;

  always_comb begin
    v_n   = v_q;
    l_n   = l_q;
    lru_n = lru_q;
    t_n   = t_q;
    if (inv_all) begin
      v_n   = v_q & l_q;
      lru_n = l_q[0] & ~l_q[1];
    end else if (sel) begin
      case (op)
        UPD_INV:   if (!l_q[way]) v_n[way] = 1'b0;
        UPD_KILL:  begin v_n[way] = 1'b0; l_n[way] = 1'b0; end
        UPD_FILL:  begin
          v_n[way] = 1'b1;
          t_n[way] = tag_in;
          l_n[way] = lock_in;
          lru_n    = ~way;
        end
        UPD_LOCK:  begin l_n[way] = 1'b1; lru_n = ~way; end
        UPD_TOUCH: lru_n = ~way;
        default:   ;
      endcase
    end
  end

  assign en = inv_all | (sel & (op != UPD_NONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      l_q   <= '0;
      lru_q <= 1'b0;
      t_q   <= '0;
    end else if (en) begin
      v_q   <= v_n;
      l_q   <= l_n;
      lru_q <= lru_n;
      t_q   <= t_n;
    end
  end

  assign valid_o = v_q;
  assign lock_o  = l_q;
  assign lru_o   = lru_q;
  assign tag_o   = t_q;
endmodule

// File: rtl/cc_lookup.sv
module cc_lookup #(
  parameter int TAG_W = 6
) (
  input  logic [TAG_W-1:0]       tag,
  input  logic [1:0]             valid,
  input  logic [1:0]             lock,
  input  logic                   lru,
  input  logic [1:0][TAG_W-1:0]  tags,
  output logic                   hit,
  output logic                   hit_way,
  output logic                   victim_way,
  output logic                   victim_ok
);
  logic [1:0] match;

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign match[w] = valid[w] && (tags[w] == tag);
  end

  assign hit        = |match;
  assign hit_way    = match[1];
  assign victim_ok  = ~(lock[0] & lock[1]);
  assign victim_way = lock[lru] ? ~lru : lru;
endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl
  import cc_pkg::*;
#(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [LINE_W-1:0] fetch_line,
  input  logic              f_hit,
  input  logic              f_hit_way,
  input  logic              f_vway,
  input  logic              f_vok,
  input  logic              csr_wr,
  input  cmd_e              cmd,
  input  logic              csr_rd,
  input  logic              problem_state,
  input  logic              adr_wr,
  input  logic [LINE_W-1:0] adr_in,
  input  logic              a_hit,
  input  logic              a_hit_way,
  input  logic              a_vway,
  input  logic              a_vok,
  input  logic              fill_done,
  input  logic              fill_err,
  output logic [LINE_W-1:0] adr_line,
  output upd_e              upd_op,
  output logic              upd_way,
  output logic [LINE_W-1:0] upd_line,
  output logic              upd_lock,
  output logic              inv_all,
  output logic              fill_req,
  output logic [LINE_W-1:0] fill_line,
  output logic              busy,
  output err_e              err,
  output logic              prog_irq,
  output logic              fetch_hit
);
  st_e               st_q, st_n;
  logic [LINE_W-1:0] fl_line_q, fl_line_n, adr_q;
  logic              fl_way_q, fl_way_n, fl_lock_q, fl_lock_n, fl_alloc_q, fl_alloc_n;
  err_e              err_q, err_n;
  logic              irq_q, cmd_go, priv_bad, fl_en;

  assign cmd_go    = csr_wr && (st_q == ST_IDLE);
  assign priv_bad  = cmd_go && problem_state && ((cmd == CMD_INV_ALL) || (cmd == CMD_LOAD_LOCK));
  assign fetch_hit = fetch_req && (st_q == ST_IDLE) && !csr_wr && f_hit;

  always_comb begin
    st_n       = st_q;
    fl_line_n  = fl_line_q;
    fl_way_n   = fl_way_q;
    fl_lock_n  = fl_lock_q;
    fl_alloc_n = fl_alloc_q;
    err_n      = csr_rd ? ERR_NONE : err_q;
    upd_op     = UPD_NONE;
    upd_way    = 1'b0;
    upd_line   = fetch_line;
    upd_lock   = 1'b0;
    inv_all    = 1'b0;
    if (st_q == ST_IDLE) begin
      if (cmd_go && !priv_bad) begin
        upd_line = adr_q;
        case (cmd)
          CMD_INV_BLK: if (a_hit) begin upd_op = UPD_INV; upd_way = a_hit_way; end
          CMD_INV_ALL: inv_all = 1'b1;
          CMD_LOAD_LOCK: begin
            if (a_hit) begin
              upd_op  = UPD_LOCK;
              upd_way = a_hit_way;
            end else if (a_vok) begin
              upd_op     = UPD_KILL;
              upd_way    = a_vway;
              st_n       = ST_FILL;
              fl_line_n  = adr_q;
              fl_way_n   = a_vway;
              fl_lock_n  = 1'b1;
              fl_alloc_n = 1'b1;
            end else begin
              err_n = ERR_NO_WAY;
            end
          end
          default: ;
        endcase
      end else if (!csr_wr && fetch_req) begin
        if (f_hit) begin
          upd_op  = UPD_TOUCH;
          upd_way = f_hit_way;
        end else begin
          st_n       = ST_FILL;
          fl_line_n  = fetch_line;
          fl_way_n   = f_vway;
          fl_lock_n  = 1'b0;
          fl_alloc_n = f_vok;
          if (f_vok) begin upd_op = UPD_KILL; upd_way = f_vway; end
        end
      end
    end else begin
      upd_line = fl_line_q;
      if (fill_err) begin
        st_n  = ST_IDLE;
        err_n = ERR_BUS;
      end else if (fill_done) begin
        st_n = ST_IDLE;
        if (fl_alloc_q) begin
          upd_op   = UPD_FILL;
          upd_way  = fl_way_q;
          upd_lock = fl_lock_q;
        end
      end
    end
  end

  assign fl_en = (st_q == ST_IDLE) && (st_n == ST_FILL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= ERR_NONE;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      err_q <= err_n;
      irq_q <= priv_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_line_q  <= '0;
      fl_way_q   <= 1'b0;
      fl_lock_q  <= 1'b0;
      fl_alloc_q <= 1'b0;
    end else if (fl_en) begin
      fl_line_q  <= fl_line_n;
      fl_way_q   <= fl_way_n;
      fl_lock_q  <= fl_lock_n;
      fl_alloc_q <= fl_alloc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      adr_q <= '0;
    else if (adr_wr) adr_q <= adr_in;
  end

  assign adr_line  = adr_q;
  assign fill_req  = (st_q == ST_FILL);
  assign fill_line = fl_line_q;
  assign busy      = (st_q == ST_FILL);
  assign err       = err_q;
  assign prog_irq  = irq_q;
endmodule

// File: rtl/lock_cache_ctl.sv
module lock_cache_ctl
  import cc_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int INDEX_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fetch_req,
  input  logic [TAG_W+INDEX_W-1:0]   fetch_line,
  output logic                       fetch_hit,
  output logic                       fetch_stall,
  input  logic                       problem_state,
  input  logic                       csr_wr,
  input  logic [1:0]                 csr_wdata,
  input  logic                       csr_rd,
  output logic [2:0]                 csr_rdata,
  input  logic                       adr_wr,
  input  logic [TAG_W+INDEX_W-1:0]   adr_wdata,
  output logic                       prog_irq,
  output logic                       fill_req,
  output logic [TAG_W+INDEX_W-1:0]   fill_line,
  input  logic                       fill_done,
  input  logic                       fill_err
);
  localparam int LINE_W = TAG_W + INDEX_W;
  localparam int SETS   = 1 << INDEX_W;

  logic [1:0]            valid_arr [SETS];
  logic [1:0]            lock_arr  [SETS];
  logic                  lru_arr   [SETS];
  logic [1:0][TAG_W-1:0] tag_arr   [SETS];
  logic [2*SETS-1:0]     valid_vec, lock_vec;
  logic [SETS-1:0]       lru_vec;

  logic [INDEX_W-1:0] f_idx, a_idx, u_idx;
  logic [LINE_W-1:0]  adr_line, upd_line;
  upd_e               upd_op;
  logic               upd_way, upd_lock, inv_all, busy;
  err_e               err;
  logic               f_hit, f_hit_way, f_vway, f_vok;
  logic               a_hit, a_hit_way, a_vway, a_vok;

  assign f_idx = fetch_line[INDEX_W-1:0];
  assign a_idx = adr_line[INDEX_W-1:0];
  assign u_idx = upd_line[INDEX_W-1:0];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    cc_set_state #(.TAG_W(TAG_W)) u_set (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (u_idx == INDEX_W'(s)),
      .op      (upd_op),
      .way     (upd_way),
      .tag_in  (upd_line[LINE_W-1:INDEX_W]),
      .lock_in (upd_lock),
      .inv_all (inv_all),
      .valid_o (valid_arr[s]),
      .lock_o  (lock_arr[s]),
      .lru_o   (lru_arr[s]),
      .tag_o   (tag_arr[s])
    );
    assign valid_vec[2*s +: 2] = valid_arr[s];
    assign lock_vec[2*s +: 2]  = lock_arr[s];
    assign lru_vec[s]          = lru_arr[s];
  end

  cc_lookup #(.TAG_W(TAG_W)) u_fetch_lu (
    .tag        (fetch_line[LINE_W-1:INDEX_W]),
    .valid      (valid_arr[f_idx]),
    .lock       (lock_arr[f_idx]),
    .lru        (lru_arr[f_idx]),
    .tags       (tag_arr[f_idx]),
    .hit        (f_hit),
    .hit_way    (f_hit_way),
    .victim_way (f_vway),
    .victim_ok  (f_vok)
  );

  cc_lookup #(.TAG_W(TAG_W)) u_adr_lu (
    .tag        (adr_line[LINE_W-1:INDEX_W]),
    .valid      (valid_arr[a_idx]),
    .lock       (lock_arr[a_idx]),
    .lru        (lru_arr[a_idx]),
    .tags       (tag_arr[a_idx]),
    .hit        (a_hit),
    .hit_way    (a_hit_way),
    .victim_way (a_vway),
    .victim_ok  (a_vok)
  );

  cc_ctrl #(.LINE_W(LINE_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_req     (fetch_req),
    .fetch_line    (fetch_line),
    .f_hit         (f_hit),
    .f_hit_way     (f_hit_way),
    .f_vway        (f_vway),
    .f_vok         (f_vok),
    .csr_wr        (csr_wr),
    .cmd           (cmd_e'(csr_wdata)),
    .csr_rd        (csr_rd),
    .problem_state (problem_state),
    .adr_wr        (adr_wr),
    .adr_in        (adr_wdata),
    .a_hit         (a_hit),
    .a_hit_way     (a_hit_way),
    .a_vway        (a_vway),
    .a_vok         (a_vok),
    .fill_done     (fill_done),
    .fill_err      (fill_err),
    .adr_line      (adr_line),
    .upd_op        (upd_op),
    .upd_way       (upd_way),
    .upd_line      (upd_line),
    .upd_lock      (upd_lock),
    .inv_all       (inv_all),
    .fill_req      (fill_req),
    .fill_line     (fill_line),
    .busy          (busy),
    .err           (err),
    .prog_irq      (prog_irq),
    .fetch_hit     (fetch_hit)
  );

  assign fetch_stall = fetch_req & ~fetch_hit;
  assign csr_rdata   = {err, busy};
endmodule

// File: rtl/cc_checker.sv
module cc_checker
  import cc_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int LINE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*SETS-1:0] valid_vec,
  input logic [2*SETS-1:0] lock_vec,
  input logic [SETS-1:0]   lru_vec,
  input logic              inv_all,
  input logic              busy,
  input logic              fetch_hit,
  input logic              fill_req,
  input logic [LINE_W-1:0] fill_line,
  input logic              fill_done,
  input logic              fill_err,
  input logic              prog_irq,
  input logic              csr_wr,
  input logic [1:0]        csr_wdata,
  input logic              problem_state
);
  logic [SETS-1:0] lk0, lk1;

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      lk0[s] = lock_vec[2*s];
      lk1[s] = lock_vec[2*s+1];
    end
  end

  // R1: a fill in progress blocks fetch service
  p_busy_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fetch_hit);

  // R2: the fill request and its address hold until answered
  p_fill_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_done && !fill_err) |=> (fill_req && $stable(fill_line)));

  // R5: unprivileged invalidate-all raises the interrupt and leaves valid bits alone
  p_priv_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !busy && problem_state && (csr_wdata == 2'(CMD_INV_ALL)))
      |=> (prog_irq && (valid_vec == $past(valid_vec))));

  // R6: after invalidate-all the replacement bit names the unlocked way
  p_invall_lru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (((lru_vec ^ $past(lk0)) & ~($past(lk0) & $past(lk1))) == '0));

  // R7: a locked line stays valid from one cycle to the next
  p_lock_keeps_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(lock_vec) & $past(valid_vec)) & ~valid_vec) == '0));

  // R9: no line is ever locked while invalid
  p_lock_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_vec & ~valid_vec) == '0);
endmodule

bind lock_cache_ctl cc_checker #(.SETS(SETS), .LINE_W(LINE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .valid_vec     (valid_vec),
  .lock_vec      (lock_vec),
  .lru_vec       (lru_vec),
  .inv_all       (inv_all),
  .busy          (busy),
  .fetch_hit     (fetch_hit),
  .fill_req      (fill_req),
  .fill_line     (fill_line),
  .fill_done     (fill_done),
  .fill_err      (fill_err),
  .prog_irq      (prog_irq),
  .csr_wr        (csr_wr),
  .csr_wdata     (csr_wdata),
  .problem_state (problem_state)
);

// File: tb/lock_cache_ctl_tb_top.sv
`timescale 1ns/1ps
module lock_cache_ctl_tb_top;
  localparam int TAG_W   = 6;
  localparam int INDEX_W = 3;
  localparam int LINE_W  = TAG_W + INDEX_W;

  localparam int K_HIT = 0, K_STALL = 1, K_RDATA = 2, K_IRQ = 3, K_FREQ = 4, K_FLINE = 5;

  logic clk, rst_n;
  logic fetch_req, fetch_hit, fetch_stall, problem_state;
  logic [LINE_W-1:0] fetch_line, adr_wdata, fill_line;
  logic csr_wr, csr_rd, adr_wr, prog_irq, fill_req, fill_done, fill_err;
  logic [1:0] csr_wdata;
  logic [2:0] csr_rdata;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  typedef struct {
    int    kind;
    int    exp;
    string rq;
  } item_t;
  item_t sb_q[$];

  lock_cache_ctl #(.TAG_W(TAG_W), .INDEX_W(INDEX_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_line(fetch_line),
    .fetch_hit(fetch_hit), .fetch_stall(fetch_stall),
    .problem_state(problem_state),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rd(csr_rd), .csr_rdata(csr_rdata),
    .adr_wr(adr_wr), .adr_wdata(adr_wdata),
    .prog_irq(prog_irq),
    .fill_req(fill_req), .fill_line(fill_line),
    .fill_done(fill_done), .fill_err(fill_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int observe(int kind);
    case (kind)
      K_HIT:   return int'(fetch_hit);
      K_STALL: return int'(fetch_stall);
      K_RDATA: return int'(csr_rdata);
      K_IRQ:   return int'(prog_irq);
      K_FREQ:  return int'(fill_req);
      default: return int'(fill_line);
    endcase
  endfunction

  // monitor: compares queued expectations against the outputs mid-cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      int    obs;
      it  = sb_q.pop_front();
      obs = observe(it.kind);
      nchk++;
      if (obs != it.exp) begin
        nerr++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.rq, it.kind, obs, it.exp);
      end
    end
  end

  task automatic expect_item(int kind, int exp, string rq);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.rq   = rq;
    sb_q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_hit(logic [LINE_W-1:0] line, string rq);
    fetch_req  = 1'b1;
    fetch_line = line;
    expect_item(K_HIT, 1, rq);
    tick();
    fetch_req = 1'b0;
  endtask

  task automatic do_miss(logic [LINE_W-1:0] line, bit alloc, string rq);
    fetch_req  = 1'b1;
    fetch_line = line;
    expect_item(K_HIT, 0, rq);
    expect_item(K_STALL, 1, rq);
    tick();
    expect_item(K_FREQ, 1, "R2");
    expect_item(K_FLINE, int'(line), "R2");
    expect_item(K_RDATA, 1, "R1");
    expect_item(K_HIT, 0, "R1");
    expect_item(K_STALL, 1, "R1");
    tick();
    fill_done = 1'b1;
    tick();
    fill_done = 1'b0;
    if (alloc) begin
      expect_item(K_HIT, 1, "R2");
      tick();
      fetch_req = 1'b0;
    end else begin
      expect_item(K_HIT, 0, "R12");
      expect_item(K_FREQ, 0, "R12");
      tick();
      expect_item(K_FREQ, 1, "R12");
      tick();
      fetch_req = 1'b0;
      fill_done = 1'b1;
      tick();
      fill_done = 1'b0;
    end
  endtask

  task automatic do_cmd(logic [1:0] code, logic [LINE_W-1:0] adr, logic ps);
    adr_wr    = 1'b1;
    adr_wdata = adr;
    tick();
    adr_wr        = 1'b0;
    problem_state = ps;
    csr_wr        = 1'b1;
    csr_wdata     = code;
    tick();
    csr_wr        = 1'b0;
    problem_state = 1'b0;
  endtask

  // line = {tag, index}
  localparam logic [LINE_W-1:0] LA = 9'h008, LB = 9'h010, LC = 9'h018, LD = 9'h020,
                                LE = 9'h028, LF = 9'h009, LP = 9'h00B, LL = 9'h00C;

  initial begin
    rst_n = 1'b0; fetch_req = 0; fetch_line = '0; problem_state = 0;
    csr_wr = 0; csr_wdata = '0; csr_rd = 0; adr_wr = 0; adr_wdata = '0;
    fill_done = 0; fill_err = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    expect_item(K_RDATA, 0, "R11");
    expect_item(K_FREQ, 0, "R11");
    expect_item(K_IRQ, 0, "R11");
    expect_item(K_STALL, 0, "R11");
    tick();

    // R2/R3: fills and replacement order in set 0
    do_miss(LA, 1, "R2");
    do_miss(LB, 1, "R2");
    do_hit(LA, "R3");
    do_miss(LC, 1, "R3");
    do_hit(LA, "R3");
    do_hit(LC, "R3");

    // R5: unprivileged load-and-lock
    do_cmd(2'd3, LA, 1'b1);
    expect_item(K_IRQ, 1, "R5");
    expect_item(K_RDATA, 0, "R5");
    tick();
    expect_item(K_IRQ, 0, "R5");
    tick();

    // R7: lock on hit, locked way never a victim
    do_cmd(2'd3, LA, 1'b0);
    expect_item(K_IRQ, 0, "R7");
    expect_item(K_RDATA, 0, "R7");
    expect_item(K_FREQ, 0, "R7");
    tick();
    do_miss(LD, 1, "R7");
    do_hit(LA, "R7");
    do_miss(LE, 1, "R7");
    do_hit(LA, "R7");
    do_cmd(2'd3, LE, 1'b0);
    expect_item(K_RDATA, 0, "R7");
    tick();

    // R8: both ways locked
    do_cmd(2'd3, LD, 1'b0);
    expect_item(K_RDATA, 2, "R8");
    expect_item(K_FREQ, 0, "R8");
    tick();
    // R10: read clears error type
    csr_rd = 1'b1;
    expect_item(K_RDATA, 2, "R10");
    tick();
    csr_rd = 1'b0;
    expect_item(K_RDATA, 0, "R10");
    tick();

    // R12: bypass fill into a fully locked set
    do_miss(LD, 0, "R12");
    do_hit(LA, "R12");
    do_hit(LE, "R12");

    // R5/R6: invalidate-all
    do_miss(LF, 1, "R2");
    do_cmd(2'd2, LA, 1'b1);
    expect_item(K_IRQ, 1, "R5");
    tick();
    do_hit(LF, "R5");
    do_cmd(2'd2, LA, 1'b0);
    expect_item(K_IRQ, 0, "R6");
    tick();
    do_hit(LA, "R6");
    do_hit(LE, "R6");
    do_miss(LF, 1, "R6");

    // R4: block invalidate at any privilege, locked lines survive
    do_cmd(2'd1, LF, 1'b1);
    expect_item(K_IRQ, 0, "R4");
    expect_item(K_RDATA, 0, "R4");
    tick();
    do_miss(LF, 1, "R4");
    do_cmd(2'd1, LA, 1'b0);
    tick();
    do_hit(LA, "R4");

    // R9: fill error
    fetch_req  = 1'b1;
    fetch_line = LP;
    tick();
    fetch_req = 1'b0;
    expect_item(K_FREQ, 1, "R9");
    tick();
    fill_err = 1'b1;
    tick();
    fill_err = 1'b0;
    expect_item(K_RDATA, 4, "R9");
    expect_item(K_FREQ, 0, "R9");
    tick();
    csr_rd = 1'b1;
    tick();
    csr_rd = 1'b0;
    do_miss(LP, 1, "R9");

    // R7 via fill, R1 command ignored while busy
    do_cmd(2'd3, LL, 1'b0);
    expect_item(K_FREQ, 1, "R7");
    expect_item(K_FLINE, int'(LL), "R7");
    expect_item(K_RDATA, 1, "R1");
    tick();
    csr_wr    = 1'b1;
    csr_wdata = 2'd2;
    tick();
    csr_wr    = 1'b0;
    fill_done = 1'b1;
    tick();
    fill_done = 1'b0;
    do_hit(LL, "R7");
    do_hit(LF, "R1");
    do_cmd(2'd2, LA, 1'b0);
    tick();
    do_hit(LL, "R7");

    tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL ALL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule